// File: doc/BRIEF.md
# Ternary Subcube Spare Remapper

This block sits in front of a memory and moves accesses that land in faulty regions over to a small spare store. The faulty regions are ternary subcubes of the combined row and column address. Each region is written as a base address plus a mask. A set mask bit means that position may take either value. A region can therefore be a scattered cluster, part of a row, part of a column, or any other subcube. It is not limited to a whole row or column.

A small table holds the regions. It is loaded and read back through a dedicated port. Each access address is compared against every valid entry in the same cycle. When several entries match, the lowest-numbered one wins. A hit sends both reads and writes to the spare store at location {winning index, offset}. The offset is formed by collecting the address bits at the entry's masked positions. A miss uses the main array. A bypass input switches the remap off, so that a device without faults runs on the main array alone. Main and spare storage are modelled as plain arrays with registered reads.

Top module: `tcam_remapper`

## Requirements
- R1: After reset every table entry reads back as invalid, and `rd_valid`, `rd_hit` and `ld_err` are low.
- R2: An entry matches an access address when its valid bit is set and every address bit whose mask bit is 0 equals the entry's base bit. Base bits under set mask bits are ignored.
- R3: When several entries match, the one with the lowest index serves the access.
- R4: The spare location is {entry index, offset}. The offset packs the address bits found at the winner's set mask positions, taken in ascending bit order, into offset bits 0, 1, … in turn. Offset bits left unfilled are 0.
- R5: A write that hits goes only to the spare store. The main array word at that address keeps its old value.
- R6: An access that matches no entry reads or writes the main array at the access address.
- R7: While `bypass` is 1, every read and write uses the main array, and `rd_hit` stays 0.
- R8: A read issued in one cycle (`acc_en`=1, `acc_we`=0) raises `rd_valid` in the next cycle, with `rd_data` and `rd_hit` for that read. `rd_valid` is 0 after any cycle with no read.
- R9: A load whose mask has more than `SPARE_DIM` bits set is rejected. The addressed entry is left unchanged, and `ld_err` is 1 for the cycle after that load only.
- R10: Setting `rb_idx` returns that entry's stored base, mask and valid bit on `rb_base`, `rb_mask` and `rb_valid` one cycle later.
- R11: An entry loaded with valid 0 never matches, so accesses in its region go to the next matching entry or to the main array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | 1 turns remapping off |
| ld_en | input | 1 | Load strobe for the entry table |
| ld_idx | input | IDX_W | Entry to load |
| ld_base | input | ADDR_W | Base address to store |
| ld_mask | input | ADDR_W | Don't-care mask to store |
| ld_valid | input | 1 | Valid bit to store |
| ld_err | output | 1 | Previous load was rejected |
| rb_idx | input | IDX_W | Entry to read back |
| rb_base | output | ADDR_W | Stored base of the entry read back |
| rb_mask | output | ADDR_W | Stored mask of the entry read back |
| rb_valid | output | 1 | Stored valid bit of the entry read back |
| acc_en | input | 1 | Access strobe |
| acc_we | input | 1 | 1 write, 0 read |
| acc_addr | input | ADDR_W | Access address, row bits above column bits |
| acc_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data is present |
| rd_hit | output | 1 | Read data came from the spare store |
| rd_data | output | DATA_W | Read data |

## Verification
A corrupted entry bit or a wrong priority choice shows up on the first read of an affected address after the cause. It appears one cycle after the request, as a flipped `rd_hit` or as data that the table could not have produced. A mistake in the offset packing is made visible by aliasing. Two entries with different masks are loaded so that they point at the same spare word. The bench then writes through one and reads through the other. Writes that leak into the main array are caught by reading the same address with `bypass` set. A rejected load that changes an entry is caught by reading the entry back in the next cycle.

// File: rtl/remap_pkg.sv
`timescale 1ns/1ps
package remap_pkg;
  // which store served a read
  typedef enum logic [0:0] {
    SRC_MAIN  = 1'b0,
    SRC_SPARE = 1'b1
  } src_e;
endpackage

// File: rtl/remap_entry_table.sv
`timescale 1ns/1ps
module remap_entry_table #(
  parameter int ADDR_W    = 6,
  parameter int ENTRIES   = 4,
  parameter int SPARE_DIM = 2,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [IDX_W-1:0]   ld_idx,
  input  logic [ADDR_W-1:0]  ld_base,
  input  logic [ADDR_W-1:0]  ld_mask,
  input  logic               ld_valid,
  output logic               ld_err,
  input  logic [IDX_W-1:0]   rb_idx,
  output logic [ADDR_W-1:0]  rb_base,
  output logic [ADDR_W-1:0]  rb_mask,
  output logic               rb_valid,
  input  logic [ADDR_W-1:0]  look_addr,
  output logic [ENTRIES-1:0] match_vec,
  input  logic [IDX_W-1:0]   sel_idx,
  output logic [ADDR_W-1:0]  sel_mask
);
  logic [ADDR_W-1:0]  ent_base [ENTRIES];
  logic [ADDR_W-1:0]  ent_mask [ENTRIES];
  logic [ENTRIES-1:0] ent_valid;
  logic               too_wide;

  assign too_wide = ($countones(ld_mask) > SPARE_DIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      ld_err    <= 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        ent_base[e] <= '0;
        ent_mask[e] <= '0;
      end
    end else begin
      ld_err <= ld_en && too_wide;
      if (ld_en && !too_wide) begin
        ent_base[ld_idx]  <= ld_base;
        ent_mask[ld_idx]  <= ld_mask;
        ent_valid[ld_idx] <= ld_valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_base  <= '0;
      rb_mask  <= '0;
      rb_valid <= 1'b0;
    end else begin
      rb_base  <= ent_base[rb_idx];
      rb_mask  <= ent_mask[rb_idx];
      rb_valid <= ent_valid[rb_idx];
    end
  end

  assign sel_mask = ent_mask[sel_idx];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = ent_valid[e] &&
                          (((look_addr ^ ent_base[e]) & ~ent_mask[e]) == '0);

    // R9
    mask_bound_chk: assert property (@(posedge clk) disable iff (rst)
      ent_valid[e] |-> ($countones(ent_mask[e]) <= SPARE_DIM));
  end

  // R9
  reject_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ($countones(ld_mask) > SPARE_DIM)) |=> ld_err);

  // R9
  reject_only_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> !ld_err);
endmodule

// File: rtl/remap_prio_enc.sv
`timescale 1ns/1ps
module remap_prio_enc #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (req[e]) idx = e[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/remap_concentrator.sv
`timescale 1ns/1ps
module remap_concentrator #(
  parameter int ADDR_W    = 6,
  parameter int SPARE_DIM = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    mask,
  output logic [SPARE_DIM-1:0] offset
);
  always_comb begin
    int slot;
    slot   = 0;
    offset = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (mask[i]) begin
        for (int k = 0; k < SPARE_DIM; k++) begin
          if (slot == k) offset[k] = addr[i];
        end
        slot = slot + 1;
      end
    end
  end
endmodule

// File: rtl/remap_storage.sv
`timescale 1ns/1ps
module remap_storage
  import remap_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int SPARE_AW = 4,
  localparam int MAIN_DEPTH  = 1 << ADDR_W,
  localparam int SPARE_DEPTH = 1 << SPARE_AW
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic                to_spare,
  input  logic [ADDR_W-1:0]   main_addr,
  input  logic [SPARE_AW-1:0] spare_addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] main_mem  [MAIN_DEPTH];
  logic [DATA_W-1:0] spare_mem [SPARE_DEPTH];
  logic [DATA_W-1:0] main_q;
  logic [DATA_W-1:0] spare_q;
  src_e              src_q;

  always_ff @(posedge clk) begin
    if (wr_en && !to_spare) main_mem[main_addr] <= wdata;
    if (rd_en && !to_spare) main_q <= main_mem[main_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en && to_spare) spare_mem[spare_addr] <= wdata;
    if (rd_en && to_spare) spare_q <= spare_mem[spare_addr];
  end

  always_ff @(posedge clk) begin
    if (rd_en) src_q <= to_spare ? SRC_SPARE : SRC_MAIN;
  end

  assign rdata = (src_q == SRC_SPARE) ? spare_q : main_q;
endmodule

// File: rtl/tcam_remapper.sv
`timescale 1ns/1ps
module tcam_remapper #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int ENTRIES   = 4,
  parameter int SPARE_DIM = 2,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int SPARE_AW = IDX_W + SPARE_DIM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [ADDR_W-1:0] ld_mask,
  input  logic              ld_valid,
  output logic              ld_err,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [ADDR_W-1:0] rb_base,
  output logic [ADDR_W-1:0] rb_mask,
  output logic              rb_valid,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ENTRIES-1:0] ENT_ONE = 1;

  logic [ENTRIES-1:0]   match_vec;
  logic                 any_match;
  logic [IDX_W-1:0]     win_idx;
  logic [ADDR_W-1:0]    win_mask;
  logic [SPARE_DIM-1:0] offset;
  logic [SPARE_AW-1:0]  spare_addr;
  logic                 to_spare;
  logic                 rd_req;
  logic                 wr_req;

  remap_entry_table #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .SPARE_DIM(SPARE_DIM)
  ) u_table (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base),
    .ld_mask(ld_mask), .ld_valid(ld_valid), .ld_err(ld_err),
    .rb_idx(rb_idx), .rb_base(rb_base), .rb_mask(rb_mask), .rb_valid(rb_valid),
    .look_addr(acc_addr), .match_vec(match_vec),
    .sel_idx(win_idx), .sel_mask(win_mask)
  );

  remap_prio_enc #(.ENTRIES(ENTRIES)) u_prio (
    .req(match_vec), .any(any_match), .idx(win_idx)
  );

  remap_concentrator #(.ADDR_W(ADDR_W), .SPARE_DIM(SPARE_DIM)) u_conc (
    .addr(acc_addr), .mask(win_mask), .offset(offset)
  );

  assign spare_addr = {win_idx, offset};
  assign to_spare   = any_match && !bypass;
  assign rd_req     = acc_en && !acc_we;
  assign wr_req     = acc_en && acc_we;

  remap_storage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPARE_AW(SPARE_AW)
  ) u_store (
    .clk(clk), .wr_en(wr_req), .rd_en(rd_req), .to_spare(to_spare),
    .main_addr(acc_addr), .spare_addr(spare_addr),
    .wdata(acc_wdata), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_hit <= to_spare;
    end
  end

  // R3
  win_is_match_chk: assert property (@(posedge clk) disable iff (rst)
    any_match |-> match_vec[win_idx]);

  // R3
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    any_match |-> ((match_vec & ((ENT_ONE << win_idx) - ENT_ONE)) == '0));

  // R7
  bypass_main_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && bypass) |=> (rd_valid && !rd_hit));

  // R8
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  // R8
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
endmodule

// File: tb/tcam_remapper_test.sv
`timescale 1ns/1ps
module tcam_remapper_test;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NE = 4;
  localparam int ND = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bypass = 1'b0;
  logic          ld_en = 1'b0;
  logic [1:0]    ld_idx = '0;
  logic [AW-1:0] ld_base = '0;
  logic [AW-1:0] ld_mask = '0;
  logic          ld_valid = 1'b0;
  logic          ld_err;
  logic [1:0]    rb_idx = '0;
  logic [AW-1:0] rb_base;
  logic [AW-1:0] rb_mask;
  logic          rb_valid;
  logic          acc_en = 1'b0;
  logic          acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic          rd_valid;
  logic          rd_hit;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [AW-1:0] m_base  [NE];
  logic [AW-1:0] m_mask  [NE];
  logic          m_valid [NE];
  logic [DW-1:0] m_main  [1 << AW];
  logic [DW-1:0] m_spare [NE << ND];

  always #2.5 clk = ~clk;

  tcam_remapper uut (
    .clk(clk), .rst(rst), .bypass(bypass),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_base(ld_base), .ld_mask(ld_mask),
    .ld_valid(ld_valid), .ld_err(ld_err),
    .rb_idx(rb_idx), .rb_base(rb_base), .rb_mask(rb_mask), .rb_valid(rb_valid),
    .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_data(rd_data)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // spare slot serving address a under the bench model, or -1 for main
  function automatic int model_slot(input logic [AW-1:0] a, input logic byp);
    if (byp) return -1;
    for (int e = 0; e < NE; e++) begin
      if (m_valid[e] && (((a ^ m_base[e]) & ~m_mask[e]) == 0)) begin
        int off;
        int k;
        off = 0;
        k = 0;
        for (int i = 0; i < AW; i++) begin
          if (m_mask[e][i]) begin
            if (k < ND) off = off + (int'(a[i]) << k);
            k++;
          end
        end
        return e * (1 << ND) + off;
      end
    end
    return -1;
  endfunction

  task automatic load(input int idx, input logic [AW-1:0] b, input logic [AW-1:0] m,
                      input logic v, input string req);
    bit bad;
    bad = ($countones(m) > ND);
    ld_en = 1'b1; ld_idx = idx[1:0]; ld_base = b; ld_mask = m; ld_valid = v;
    tick();
    ld_en = 1'b0;
    check(req, {31'd0, ld_err}, {31'd0, bad});
    if (!bad) begin
      m_base[idx] = b; m_mask[idx] = m; m_valid[idx] = v;
    end
  endtask

  task automatic readback(input int idx, input string req);
    rb_idx = idx[1:0];
    tick();
    check(req, {26'd0, rb_base}, {26'd0, m_base[idx]});
    check(req, {26'd0, rb_mask}, {26'd0, m_mask[idx]});
    check(req, {31'd0, rb_valid}, {31'd0, m_valid[idx]});
  endtask

  task automatic write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic byp);
    int s;
    s = model_slot(a, byp);
    bypass = byp; acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    tick();
    acc_en = 1'b0; acc_we = 1'b0;
    if (s < 0) m_main[a] = d;
    else m_spare[s] = d;
  endtask

  task automatic read(input logic [AW-1:0] a, input logic byp, input string req);
    int s;
    s = model_slot(a, byp);
    bypass = byp; acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    tick();
    acc_en = 1'b0;
    check("R8", {31'd0, rd_valid}, 32'd1);
    check(req, {31'd0, rd_hit}, {31'd0, (s >= 0)});
    check(req, {24'd0, rd_data}, {24'd0, (s < 0) ? m_main[a] : m_spare[s]});
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin
      m_base[e] = '0; m_mask[e] = '0; m_valid[e] = 1'b0;
    end
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1", {31'd0, rd_valid}, 32'd0);
    check("R1", {31'd0, rd_hit}, 32'd0);
    check("R1", {31'd0, ld_err}, 32'd0);
    for (int e = 0; e < NE; e++) readback(e, "R1");

    // R6 fill and read back main array with an empty table
    for (int a = 0; a < 64; a++) write(a[AW-1:0], DW'(a * 7 + 3), 1'b0);
    for (int a = 0; a < 64; a++) read(a[AW-1:0], 1'b0, "R6");
    tick();
    check("R8", {31'd0, rd_valid}, 32'd0);

    // R2 R3 overlapping entries, R9 rejection, R10 readback
    load(0, 6'b001000, 6'b000011, 1'b1, "R9");
    load(1, 6'b000101, 6'b001010, 1'b1, "R9");   // base bits 0,2 clash: bit 2 checked
    load(1, 6'b000000, 6'b001010, 1'b1, "R9");
    load(2, 6'b010011, 6'b100100, 1'b1, "R9");
    load(3, 6'b000000, 6'b000111, 1'b1, "R9");   // three mask bits: rejected
    tick();
    check("R9", {31'd0, ld_err}, 32'd0);
    for (int e = 0; e < NE; e++) readback(e, "R10");

    // R2 R3 R4 R5 sweep writes and reads through the remap
    for (int a = 0; a < 64; a++) write(a[AW-1:0], DW'(a * 13 + 90), 1'b0);
    for (int a = 0; a < 64; a++) read(a[AW-1:0], 1'b0, "R2");
    // R5 R7 main array untouched at remapped addresses
    for (int a = 0; a < 64; a++) read(a[AW-1:0], 1'b1, "R5");

    // R11 invalidate entry 0, then rewrite and reread
    load(0, 6'b001000, 6'b000011, 1'b0, "R11");
    for (int a = 0; a < 64; a++) write(a[AW-1:0], DW'(a * 5 + 17), 1'b0);
    for (int a = 0; a < 64; a++) read(a[AW-1:0], 1'b0, "R11");

    // R7 bypass writes land in main only
    write(6'd19, 8'hE7, 1'b1);
    read(6'd19, 1'b1, "R7");
    read(6'd19, 1'b0, "R7");

    // R4 ordering: two masks aliasing one spare word
    load(1, 6'b000000, 6'b000000, 1'b0, "R4");
    load(2, 6'b000000, 6'b000000, 1'b0, "R4");
    load(0, 6'b000000, 6'b100001, 1'b1, "R4");
    write(6'b000001, 8'hC3, 1'b0);          // offset 01 -> spare word 1
    write(6'b100000, 8'h3C, 1'b0);          // offset 10 -> spare word 2
    load(0, 6'b000000, 6'b001100, 1'b1, "R4");
    read(6'b000100, 1'b0, "R4");            // bit2=1 bit3=0 -> word 1
    check("R4", {24'd0, rd_data}, 32'h0000_00C3);
    read(6'b001000, 1'b0, "R4");            // bit2=0 bit3=1 -> word 2
    check("R4", {24'd0, rd_data}, 32'h0000_003C);
    load(0, 6'b000000, 6'b000100, 1'b1, "R4");
    read(6'b000100, 1'b0, "R4");            // one mask bit: offset 01
    check("R4", {24'd0, rd_data}, 32'h0000_00C3);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule